// File: doc/BRIEF.md
# Bit-Reversed Write Address Generator

This block computes the effective address and the pointer write-back value for one data access per request. For word-sized writes through a pre-increment or post-increment pointer, with bit reversal enabled and a pointer index other than the stack pointer's, it combines the pointer with a pivot modifier using reverse-carry addition. Successive writes then land in bit-reversed index order, which is the reordering step of a radix-2 FFT. The pivot is given in words and equals half the transform length. It is scaled by two to form a byte modifier.

Any access that does not qualify takes the normal path. That path covers plain indirect, pre/post increment and decrement by the access size, and pointer-plus-offset. An optional modulo corrector wraps modified addresses into a circular buffer. On the write path bit reversal outranks modulo: a write with bit reversal enabled is never modulo-corrected, while reads keep modulo correction. Results are registered, so they appear one clock after the request.

Top module: `brev_agu`

## Requirements
- R1: While rst_ni is low, out_valid_o, ea_o, wb_o, brev_act_o and mod_act_o are all 0.
- R2: A request with req_valid_i high is reflected on the outputs after the next rising clock edge, with out_valid_o high for that one cycle. Without a request, out_valid_o is 0 and ea_o, wb_o and the flags hold their values.
- R3: Bit reversal is applied (brev_act_o=1) only when brev_en_i=1, wr_i=1, byte_i=0, ptr_sel_i is not 15, and mode_i is 2 (post-increment) or 4 (pre-increment). Otherwise the normal address path is used.
- R4: The bit-reversed result is the sum of ptr_i and {pivot_i,1'b0}, with carries moving from bit 15 toward bit 1. Any carry out of bit 1 is dropped, bit 0 is 0, and bits above the highest set modifier bit keep their pointer value.
- R5: When bit reversal is active, post-increment gives ea_o = ptr_i with bit 0 cleared and wb_o = the bit-reversed result. Pre-increment gives ea_o = wb_o = the bit-reversed result. The size step is not added.
- R6: Normal modes use a step of 1 for byte_i=1 and 2 otherwise, with this mode_i encoding. 0 is plain indirect: ea=wb=ptr. 1 is post-decrement: ea=ptr, wb=ptr-step. 2 is post-increment: ea=ptr, wb=ptr+step. 3 is pre-decrement: ea=wb=ptr-step. 4 is pre-increment: ea=wb=ptr+step. Codes 6 and 7 behave as 0.
- R7: Mode 5 (offset) gives ea_o = ptr_i + off_i and wb_o = ptr_i.
- R8: With mod_en_i=1, an increment or offset result above mod_end_i is reduced by (mod_end_i - mod_start_i + 1). A decrement or offset result below mod_start_i is raised by the same length. mod_act_o=1 exactly when such a wrap happened.
- R9: A write (wr_i=1) with brev_en_i=1 is never modulo-corrected and gives mod_act_o=0. Reads keep modulo correction regardless of brev_en_i.
- R10: With the buffer base aligned to its size in bytes, and pivot_i equal to half its word count, 2^N successive post-increment writes that each feed wb_o back as the next pointer visit every word exactly once, in bit-reversed index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe; captures a new result |
| ptr_i | input | 16 | Pointer register value |
| ptr_sel_i | input | 4 | Index of the pointer register (15 = stack pointer) |
| mode_i | input | 3 | Addressing mode code |
| byte_i | input | 1 | 1 = byte access, 0 = word access |
| wr_i | input | 1 | 1 = write, 0 = read |
| off_i | input | 16 | Offset for mode 5 |
| brev_en_i | input | 1 | Bit-reversal enable |
| pivot_i | input | 15 | Pivot modifier in words |
| mod_en_i | input | 1 | Modulo correction enable |
| mod_start_i | input | 16 | Circular buffer first byte |
| mod_end_i | input | 16 | Circular buffer last byte |
| out_valid_o | output | 1 | Result strobe |
| ea_o | output | 16 | Effective address |
| wb_o | output | 16 | Pointer write-back value |
| brev_act_o | output | 1 | Bit reversal was applied |
| mod_act_o | output | 1 | Modulo wrap was applied |

## Verification
The hold property assumes that every output change comes from a request. The qualification and arbitration properties assume the inputs are stable while req_valid_i is sampled. The bench meets both by driving every input on the falling edge and raising the strobe for exactly one cycle per request. Modulo bounds are assumed ordered (start not above end) and pivot buffers size-aligned. The stimulus only uses aligned bases and ordered bounds, so the wrap arithmetic and the sweep stay within the defined cases.

// File: rtl/brev_pkg.sv
package brev_pkg;
  typedef enum logic [2:0] {
    AM_PLAIN    = 3'd0,
    AM_POST_DEC = 3'd1,
    AM_POST_INC = 3'd2,
    AM_PRE_DEC  = 3'd3,
    AM_PRE_INC  = 3'd4,
    AM_OFFSET   = 3'd5
  } amode_e;

  function automatic amode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd1:    return AM_POST_DEC;
      3'd2:    return AM_POST_INC;
      3'd3:    return AM_PRE_DEC;
      3'd4:    return AM_PRE_INC;
      3'd5:    return AM_OFFSET;
      default: return AM_PLAIN;
    endcase
  endfunction
endpackage

// File: rtl/brev_rc_adder.sv
// Reverse-carry adder over bits [W-1:1]; bit 0 forced low (word addressing).
module brev_rc_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  localparam int FW = W - 1;

  logic [FW-1:0] a_rev, b_rev, s_rev;

  for (genvar g = 0; g < FW; g++) begin : g_rev
    assign a_rev[g]         = a_i[W-1-g];
    assign b_rev[g]         = b_i[W-1-g];
    assign sum_o[W-1-g]     = s_rev[g];
  end

  // carry out of the reversed MSB (original bit 1) is dropped
  assign s_rev    = a_rev + b_rev;
  assign sum_o[0] = 1'b0;

  logic unused_lsb;
  assign unused_lsb = a_i[0] ^ b_i[0];
endmodule

// File: rtl/brev_qualify.sv
module brev_qualify
  import brev_pkg::*;
#(
  parameter int SEL_W  = 4,
  parameter int SP_IDX = 15
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  amode_e           mode_i,
  input  logic             byte_i,
  input  logic             wr_i,
  output logic             act_o
);
  logic mode_ok;
  assign mode_ok = (mode_i == AM_POST_INC) || (mode_i == AM_PRE_INC);
  assign act_o   = en_i && wr_i && !byte_i && mode_ok &&
                   (sel_i != SEL_W'(SP_IDX));
endmodule

// File: rtl/brev_modulo.sv
module brev_modulo #(
  parameter int W = 16
) (
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] end_i,
  input  logic         up_i,
  input  logic         dn_i,
  output logic [W-1:0] addr_o,
  output logic         hit_o
);
  logic [W-1:0] len;
  assign len = end_i - start_i + W'(1);

  always_comb begin
    addr_o = addr_i;
    hit_o  = 1'b0;
    if (up_i && (addr_i > end_i)) begin
      addr_o = addr_i - len;
      hit_o  = 1'b1;
    end else if (dn_i && (addr_i < start_i)) begin
      addr_o = addr_i + len;
      hit_o  = 1'b1;
    end
  end
endmodule

// File: rtl/brev_agu.sv
module brev_agu
  import brev_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 4,
  parameter int SP_IDX = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [SEL_W-1:0]  ptr_sel_i,
  input  logic [2:0]        mode_i,
  input  logic              byte_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic              brev_en_i,
  input  logic [ADDR_W-2:0] pivot_i,
  input  logic              mod_en_i,
  input  logic [ADDR_W-1:0] mod_start_i,
  input  logic [ADDR_W-1:0] mod_end_i,
  output logic              out_valid_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic [ADDR_W-1:0] wb_o,
  output logic              brev_act_o,
  output logic              mod_act_o
);
  localparam int PIV_W = ADDR_W - 1;

  amode_e            mode;
  logic              brev_act;
  logic [ADDR_W-1:0] xb, rc_sum, step, raw, fixed;
  logic              up, dn, mod_allow, wrap;
  logic [ADDR_W-1:0] ea_d, wb_d;

  assign mode = decode_mode(mode_i);
  assign xb   = {pivot_i[PIV_W-1:0], 1'b0};   // word pivot -> byte modifier
  assign step = byte_i ? ADDR_W'(1) : ADDR_W'(2);

  brev_qualify #(.SEL_W(SEL_W), .SP_IDX(SP_IDX)) u_qual (
    .en_i   (brev_en_i),
    .sel_i  (ptr_sel_i),
    .mode_i (mode),
    .byte_i (byte_i),
    .wr_i   (wr_i),
    .act_o  (brev_act)
  );

  brev_rc_adder #(.W(ADDR_W)) u_rca (
    .a_i   (ptr_i),
    .b_i   (xb),
    .sum_o (rc_sum)
  );

  // write path: bit reversal enabled locks out modulo
  assign mod_allow = mod_en_i && !(wr_i && brev_en_i);

  always_comb begin
    raw = ptr_i;
    up  = 1'b0;
    dn  = 1'b0;
    unique case (mode)
      AM_POST_INC, AM_PRE_INC: begin raw = ptr_i + step;  up = 1'b1; end
      AM_POST_DEC, AM_PRE_DEC: begin raw = ptr_i - step;  dn = 1'b1; end
      AM_OFFSET:               begin raw = ptr_i + off_i; up = 1'b1; dn = 1'b1; end
      default:                 raw = ptr_i;
    endcase
  end

  brev_modulo #(.W(ADDR_W)) u_mod (
    .addr_i  (raw),
    .start_i (mod_start_i),
    .end_i   (mod_end_i),
    .up_i    (up && mod_allow),
    .dn_i    (dn && mod_allow),
    .addr_o  (fixed),
    .hit_o   (wrap)
  );

  always_comb begin
    ea_d = ptr_i;
    wb_d = ptr_i;
    if (brev_act) begin
      if (mode == AM_PRE_INC) begin
        ea_d = rc_sum;
        wb_d = rc_sum;
      end else begin
        ea_d = {ptr_i[ADDR_W-1:1], 1'b0};
        wb_d = rc_sum;
      end
    end else begin
      unique case (mode)
        AM_POST_INC, AM_POST_DEC: begin ea_d = ptr_i; wb_d = fixed; end
        AM_PRE_INC,  AM_PRE_DEC:  begin ea_d = fixed; wb_d = fixed; end
        AM_OFFSET:                begin ea_d = fixed; wb_d = ptr_i; end
        default:                  begin ea_d = ptr_i; wb_d = ptr_i; end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      ea_o        <= '0;
      wb_o        <= '0;
      brev_act_o  <= 1'b0;
      mod_act_o   <= 1'b0;
    end else begin
      out_valid_o <= req_valid_i;
      if (req_valid_i) begin
        ea_o       <= ea_d;
        wb_o       <= wb_d;
        brev_act_o <= brev_act;
        mod_act_o  <= wrap && !brev_act;
      end
    end
  end

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(ea_o) && $stable(wb_o) && !out_valid_o));

  a_r3_qualify: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (!wr_i || byte_i || !brev_en_i ||
                     ptr_sel_i == SEL_W'(SP_IDX))) |=> !brev_act_o);

  a_r5_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brev_act_o |-> (!ea_o[0] && !wb_o[0]));

  a_r9_write_no_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && wr_i && brev_en_i) |=> !mod_act_o);

  a_r9_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(brev_act_o && mod_act_o));
endmodule

// File: tb/sim_brev_agu.sv
module sim_brev_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] ptr = '0, off = '0, ms = '0, me = '0;
  logic [3:0]  sel = '0;
  logic [2:0]  mode = '0;
  logic        byt = 1'b0, wr = 1'b0, en = 1'b0, men = 1'b0;
  logic [14:0] piv = '0;
  logic        out_valid, brev_act, mod_act;
  logic [15:0] ea, wb;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  brev_agu u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .ptr_i(ptr),
    .ptr_sel_i(sel), .mode_i(mode), .byte_i(byt), .wr_i(wr), .off_i(off),
    .brev_en_i(en), .pivot_i(piv), .mod_en_i(men), .mod_start_i(ms),
    .mod_end_i(me), .out_valid_o(out_valid), .ea_o(ea), .wb_o(wb),
    .brev_act_o(brev_act), .mod_act_o(mod_act)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic        wr, byt, en;
    logic [3:0]  sel;
    logic [15:0] ptr;
    logic [14:0] piv;
    logic [15:0] off;
    logic        men;
    logic [15:0] ms, me;
    logic [15:0] ea, wb;
    logic        br, md;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    // R4 R5: pivot 4 (8-word buffer) post/pre increment
    '{3'd2,1'b1,1'b0,1'b1,4'd2,16'h1000,15'd4,16'h0,1'b0,16'h0,16'h0,16'h1000,16'h1008,1'b1,1'b0,4'd5},
    '{3'd2,1'b1,1'b0,1'b1,4'd2,16'h1008,15'd4,16'h0,1'b0,16'h0,16'h0,16'h1008,16'h1004,1'b1,1'b0,4'd4},
    '{3'd4,1'b1,1'b0,1'b1,4'd2,16'h100C,15'd4,16'h0,1'b0,16'h0,16'h0,16'h1002,16'h1002,1'b1,1'b0,4'd5},
    '{3'd2,1'b1,1'b0,1'b1,4'd2,16'h100E,15'd4,16'h0,1'b0,16'h0,16'h0,16'h100E,16'h1000,1'b1,1'b0,4'd4},
    // R3: byte write, read, stack pointer index, decrement mode
    '{3'd2,1'b1,1'b1,1'b1,4'd2,16'h1000,15'd4,16'h0,1'b0,16'h0,16'h0,16'h1000,16'h1001,1'b0,1'b0,4'd3},
    '{3'd2,1'b0,1'b0,1'b1,4'd2,16'h1000,15'd4,16'h0,1'b0,16'h0,16'h0,16'h1000,16'h1002,1'b0,1'b0,4'd3},
    '{3'd2,1'b1,1'b0,1'b1,4'd15,16'h1000,15'd4,16'h0,1'b0,16'h0,16'h0,16'h1000,16'h1002,1'b0,1'b0,4'd3},
    '{3'd1,1'b1,1'b0,1'b1,4'd2,16'h1000,15'd4,16'h0,1'b0,16'h0,16'h0,16'h1000,16'h0FFE,1'b0,1'b0,4'd3},
    // R6 R7: normal modes
    '{3'd3,1'b0,1'b0,1'b0,4'd1,16'h2000,15'd0,16'h0,1'b0,16'h0,16'h0,16'h1FFE,16'h1FFE,1'b0,1'b0,4'd6},
    '{3'd5,1'b0,1'b0,1'b0,4'd1,16'h2000,15'd0,16'h10,1'b0,16'h0,16'h0,16'h2010,16'h2000,1'b0,1'b0,4'd7},
    '{3'd0,1'b1,1'b0,1'b1,4'd1,16'h2345,15'd4,16'h0,1'b0,16'h0,16'h0,16'h2345,16'h2345,1'b0,1'b0,4'd6},
    // R8: modulo wraps on reads
    '{3'd2,1'b0,1'b0,1'b0,4'd1,16'h200E,15'd0,16'h0,1'b1,16'h2000,16'h200F,16'h200E,16'h2000,1'b0,1'b1,4'd8},
    '{3'd3,1'b0,1'b0,1'b0,4'd1,16'h2000,15'd0,16'h0,1'b1,16'h2000,16'h200F,16'h200E,16'h200E,1'b0,1'b1,4'd8},
    // R9: arbitration on writes
    '{3'd2,1'b1,1'b0,1'b1,4'd2,16'h2006,15'd4,16'h0,1'b1,16'h2000,16'h200F,16'h2006,16'h200E,1'b1,1'b0,4'd9},
    '{3'd2,1'b1,1'b1,1'b1,4'd2,16'h200F,15'd4,16'h0,1'b1,16'h2000,16'h200F,16'h200F,16'h2010,1'b0,1'b0,4'd9},
    '{3'd2,1'b1,1'b0,1'b0,4'd2,16'h200E,15'd4,16'h0,1'b1,16'h2000,16'h200F,16'h200E,16'h2000,1'b0,1'b1,4'd9},
    // R4: upper bits kept, odd pointer
    '{3'd2,1'b1,1'b0,1'b1,4'd3,16'hABCD,15'd16,16'h0,1'b0,16'h0,16'h0,16'hABCC,16'hABEC,1'b1,1'b0,4'd4},
    '{3'd2,1'b1,1'b0,1'b1,4'd3,16'hABED,15'd16,16'h0,1'b0,16'h0,16'h0,16'hABEC,16'hABDC,1'b1,1'b0,4'd4}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue();
    @(negedge clk) req_valid = 1'b1;
    @(negedge clk) req_valid = 1'b0;
  endtask

  function automatic int rev4(input int k);
    int r = 0;
    for (int b = 0; b < 4; b++) if (k[b]) r |= (1 << (3 - b));
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit seen [16];
    logic [15:0] p;
    logic [15:0] ea_hold, wb_hold;

    // R1: reset state
    repeat (3) @(negedge clk);
    check({out_valid, ea, wb, brev_act, mod_act} == '0, "R1 reset",
          {out_valid, brev_act, mod_act, 13'd0}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      mode = VECS[i].mode; wr = VECS[i].wr; byt = VECS[i].byt; en = VECS[i].en;
      sel = VECS[i].sel; ptr = VECS[i].ptr; piv = VECS[i].piv; off = VECS[i].off;
      men = VECS[i].men; ms = VECS[i].ms; me = VECS[i].me;
      issue();
      check(ea == VECS[i].ea, $sformatf("R%0d vec%0d ea", VECS[i].req, i), ea, VECS[i].ea);
      check(wb == VECS[i].wb, $sformatf("R%0d vec%0d wb", VECS[i].req, i), wb, VECS[i].wb);
      check({brev_act, mod_act} == {VECS[i].br, VECS[i].md},
            $sformatf("R%0d vec%0d flags", VECS[i].req, i),
            {brev_act, mod_act}, {VECS[i].br, VECS[i].md});
    end

    // R2: strobe for one cycle, hold while idle
    ptr = 16'h3000; mode = 3'd0; en = 1'b0; men = 1'b0;
    issue();
    ea_hold = ea; wb_hold = wb;
    ptr = 16'h4444; mode = 3'd4;
    @(negedge clk);
    check(!out_valid && ea == ea_hold && wb == wb_hold, "R2 hold",
          {ea, wb}, {ea_hold, wb_hold});
    check(ea_hold == 16'h3000, "R2 capture", ea_hold, 32'h3000);

    // R6: codes 6 and 7 act as plain indirect
    mode = 3'd7; ptr = 16'h0102;
    issue();
    check(ea == 16'h0102 && wb == 16'h0102, "R6 code7", {ea, wb}, {16'h0102, 16'h0102});

    // R10: 16-word sweep, base 0x0400 (32-byte aligned), pivot 8
    mode = 3'd2; wr = 1'b1; byt = 1'b0; en = 1'b1; sel = 4'd5; piv = 15'd8;
    men = 1'b1; ms = 16'h0400; me = 16'h041F;
    p = 16'h0400;
    for (int k = 0; k < 16; k++) begin
      int idx;
      ptr = p;
      issue();
      idx = int'((ea - 16'h0400) >> 1);
      check(idx == rev4(k) && ea[15:5] == 11'h020, $sformatf("R10 step%0d", k), idx, rev4(k));
      if (idx >= 0 && idx < 16) seen[idx] = 1'b1;
      p = wb;
    end
    begin
      int cnt = 0;
      for (int j = 0; j < 16; j++) if (seen[j]) cnt++;
      check(cnt == 16, "R10 coverage", cnt, 16);
    end
    check(p == 16'h0400, "R10 return", p, 32'h0400);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule